// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the exception state of the system-control coprocessor of a small 32-bit core: the status register (SR) with its three-level mode and interrupt-enable stack, the Cause register and the exception PC (EPC). The pipeline reports a faulting instruction together with its cause code, its PC, its delay-slot and branch-taken flags, and the coprocessor field of the instruction word. The block then pushes the enable stack, builds Cause, chooses EPC and sends fetch to the proper vector for one cycle. A return strobe pops the stack. The pipeline also reports reads of control registers. A read of an unimplemented register index becomes a reserved-instruction fault.

Software writes SR and the two software-interrupt pending bits of Cause through a shared write-data port. The block raises a software-interrupt request whenever a pending bit meets its mask bit while interrupts are enabled. All state is registered, so every effect appears on the outputs one clock after the inputs that cause it.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, sr_o, cause_o, epc_o and redirect_pc_o are zero, and redirect_valid_o and swi_req_o are low.
- R2: When an exception is taken, SR bits 5:0 become the old bits 3:0 shifted up by two places, which clears bits 1:0. SR bits 31:6 do not change.
- R3: When rfe_i is applied with no exception taken in the same cycle, SR bits 3:0 take the old bits 5:2. SR bits 31:4 do not change.
- R4: When an exception is taken, Cause bits 9:8 are kept, the cause code is written to bits 6:2, and every other bit is cleared unless R5 or R6 sets it.
- R5: Cause bit 31 is set to exc_in_slot_i, and bit 30 is set to exc_in_slot_i AND exc_br_taken_i. EPC is exc_pc_i minus 4 for a delay-slot fault and exc_pc_i otherwise.
- R6: Cause bits 29:28 take exc_cop_i (instruction bits 27:26) when exc_from_insn_i is set on a general request or the fault is a reserved register read. In every other case these bits are zero.
- R7: A general exception redirects to 0x80000080. A request with exc_dbg_i set is a debug breakpoint: it redirects to 0x80000040 and uses code 9, whatever exc_code_i holds.
- R8: creg_rd_i with creg_idx_i equal to 0, 1, 2, 4 or 10 raises an exception with code 10 that uses exc_pc_i and the delay-slot flags. A read of any other index changes no output.
- R9: swi_req_o is high when SR bit 0 is set and (Cause AND SR) has a bit set in 9:8. The output reflects the registers, so a write shows its effect one cycle later.
- R10: A request in the cycle right after an accepted exception is ignored. Only one exception is taken per cycle.
- R11: In a given cycle, a taken exception has priority over rfe_i, and rfe_i has priority over register writes. The lower-priority action is dropped. sr_we_i loads all 32 bits of SR. cause_we_i loads only Cause bits 9:8.
- R12: redirect_valid_o is a one-cycle pulse for each taken exception. redirect_pc_o holds the last vector between exceptions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception request from the pipeline |
| exc_dbg_i | input | 1 | Request is a debug breakpoint |
| exc_code_i | input | 5 | Cause code of a general request |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| exc_in_slot_i | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_br_taken_i | input | 1 | The branch that owns the slot was taken |
| exc_from_insn_i | input | 1 | Fault raised by the instruction itself |
| exc_cop_i | input | 2 | Instruction bits 27:26 (coprocessor number) |
| creg_rd_i | input | 1 | Control-register read is in progress |
| creg_idx_i | input | 5 | Index of the control register being read |
| rfe_i | input | 1 | Return-from-exception strobe |
| sr_we_i | input | 1 | Write SR |
| cause_we_i | input | 1 | Write the Cause software-pending bits |
| wdata_i | input | 32 | Write data for SR and Cause |
| sr_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception PC |
| redirect_valid_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| swi_req_o | output | 1 | Software-interrupt request |

## Verification
Exception entry can land in the same cycle as a return strobe or as a software write to SR or Cause. Both updates touch the enable stack or the pending bits. The bench drives these pairs together in one cycle. It expects the registers to show only the higher-priority action and to show no trace of the one that was dropped. The bench also drives a second request in the cycle right after an accepted one, and it judges that this request left every output unchanged.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_TRAP  = 2'd1,
    EV_RFE   = 2'd2,
    EV_WRITE = 2'd3
  } trap_ev_e;

  localparam int unsigned CODE_W  = 5;
  localparam logic [CODE_W-1:0] CODE_BP = 5'd9;
  localparam logic [CODE_W-1:0] CODE_RI = 5'd10;

  // Cause field positions
  localparam int unsigned CS_SLOT  = 31;
  localparam int unsigned CS_TAKEN = 30;
  localparam int unsigned CS_COP_L = 28;
  localparam int unsigned CS_SW_L  = 8;
  localparam int unsigned CS_CODE_L = 2;
endpackage

// File: rtl/trap_select.sv
`timescale 1ns/1ps
module trap_select
  import trap_pkg::*;
#(
  parameter int unsigned IDX_W     = 5,
  parameter logic [(1<<IDX_W)-1:0] RSVD_MASK = 32'h0000_0417
) (
  input  logic              busy_i,
  input  logic              exc_req_i,
  input  logic              exc_dbg_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              exc_from_insn_i,
  input  logic [1:0]        exc_cop_i,
  input  logic              creg_rd_i,
  input  logic [IDX_W-1:0]  creg_idx_i,
  input  logic              rfe_i,
  input  logic              sr_we_i,
  input  logic              cause_we_i,
  output trap_ev_e          ev_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        cop_o,
  output logic              dbg_o
);
  logic rd_fault, take, cop_en;

  assign rd_fault = creg_rd_i & RSVD_MASK[creg_idx_i];
  assign take     = (exc_req_i | rd_fault) & ~busy_i;

  always_comb begin
    if (take)                       ev_o = EV_TRAP;
    else if (rfe_i)                 ev_o = EV_RFE;
    else if (sr_we_i | cause_we_i)  ev_o = EV_WRITE;
    else                            ev_o = EV_IDLE;
  end

  always_comb begin
    if (exc_req_i) begin
      code_o = exc_dbg_i ? CODE_BP : exc_code_i;
      cop_en = exc_from_insn_i & ~exc_dbg_i;
      dbg_o  = exc_dbg_i;
    end else begin
      code_o = CODE_RI;
      cop_en = 1'b1;
      dbg_o  = 1'b0;
    end
  end

  assign cop_o = cop_en ? exc_cop_i : 2'b00;
endmodule

// File: rtl/trap_sr_stack.sv
`timescale 1ns/1ps
module trap_sr_stack
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned LEVELS = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  trap_ev_e        ev_i,
  input  logic            sr_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] sr_o
);
  localparam int unsigned STACK_W = 2 * LEVELS;

  logic [XLEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      unique case (ev_i)
        EV_TRAP:  sr_q[STACK_W-1:0] <= {sr_q[STACK_W-3:0], 2'b00};
        EV_RFE:   sr_q[STACK_W-3:0] <= sr_q[STACK_W-1:2];
        EV_WRITE: if (sr_we_i) sr_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/trap_cause_epc.sv
`timescale 1ns/1ps
module trap_cause_epc
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  trap_ev_e          ev_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        cop_i,
  input  logic              slot_i,
  input  logic              taken_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              cause_we_i,
  input  logic [1:0]        sw_wdata_i,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o
);
  logic [XLEN-1:0] cause_q, epc_q, trap_cause;

  always_comb begin
    trap_cause = '0;
    trap_cause[CS_SLOT]                 = slot_i;
    trap_cause[CS_TAKEN]                = slot_i & taken_i;
    trap_cause[CS_COP_L +: 2]           = cop_i;
    trap_cause[CS_SW_L +: 2]            = cause_q[CS_SW_L +: 2];
    trap_cause[CS_CODE_L +: CODE_W]     = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      unique case (ev_i)
        EV_TRAP: begin
          cause_q <= trap_cause;
          epc_q   <= slot_i ? pc_i - XLEN'(4) : pc_i;
        end
        EV_WRITE: if (cause_we_i) cause_q[CS_SW_L +: 2] <= sw_wdata_i;
        default: ;
      endcase
    end
  end

  assign cause_o = cause_q;
  assign epc_o   = epc_q;
endmodule

// File: rtl/trap_sequencer.sv
`timescale 1ns/1ps
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned LEVELS  = 3,
  parameter logic [(1<<IDX_W)-1:0] RSVD_MASK = 32'h0000_0417,
  parameter logic [XLEN-1:0] GEN_VEC = 32'h8000_0080,
  parameter logic [XLEN-1:0] DBG_VEC = 32'h8000_0040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic              exc_dbg_i,
  input  logic [4:0]        exc_code_i,
  input  logic [XLEN-1:0]   exc_pc_i,
  input  logic              exc_in_slot_i,
  input  logic              exc_br_taken_i,
  input  logic              exc_from_insn_i,
  input  logic [1:0]        exc_cop_i,
  input  logic              creg_rd_i,
  input  logic [IDX_W-1:0]  creg_idx_i,
  input  logic              rfe_i,
  input  logic              sr_we_i,
  input  logic              cause_we_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              swi_req_o
);
  trap_ev_e          ev;
  logic [CODE_W-1:0] code;
  logic [1:0]        cop;
  logic              dbg;
  logic              rv_q;
  logic [XLEN-1:0]   rpc_q;

  trap_select #(.IDX_W(IDX_W), .RSVD_MASK(RSVD_MASK)) u_select (
    .busy_i          (rv_q),
    .exc_req_i       (exc_req_i),
    .exc_dbg_i       (exc_dbg_i),
    .exc_code_i      (exc_code_i),
    .exc_from_insn_i (exc_from_insn_i),
    .exc_cop_i       (exc_cop_i),
    .creg_rd_i       (creg_rd_i),
    .creg_idx_i      (creg_idx_i),
    .rfe_i           (rfe_i),
    .sr_we_i         (sr_we_i),
    .cause_we_i      (cause_we_i),
    .ev_o            (ev),
    .code_o          (code),
    .cop_o           (cop),
    .dbg_o           (dbg)
  );

  trap_sr_stack #(.XLEN(XLEN), .LEVELS(LEVELS)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .sr_we_i (sr_we_i),
    .wdata_i (wdata_i),
    .sr_o    (sr_o)
  );

  trap_cause_epc #(.XLEN(XLEN)) u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .code_i     (code),
    .cop_i      (cop),
    .slot_i     (exc_in_slot_i),
    .taken_i    (exc_br_taken_i),
    .pc_i       (exc_pc_i),
    .cause_we_i (cause_we_i),
    .sw_wdata_i (wdata_i[CS_SW_L +: 2]),
    .cause_o    (cause_o),
    .epc_o      (epc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q  <= 1'b0;
      rpc_q <= '0;
    end else begin
      rv_q <= (ev == EV_TRAP);
      if (ev == EV_TRAP) rpc_q <= dbg ? DBG_VEC : GEN_VEC;
    end
  end

  assign redirect_valid_o = rv_q;
  assign redirect_pc_o    = rpc_q;
  assign swi_req_o = sr_o[0] & |(cause_o[CS_SW_L +: 2] & sr_o[CS_SW_L +: 2]);
endmodule

// File: rtl/trap_sequencer_chk.sv
`timescale 1ns/1ps
module trap_sequencer_chk #(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] GEN_VEC = 32'h8000_0080,
  parameter logic [XLEN-1:0] DBG_VEC = 32'h8000_0040
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_in_slot_i,
  input logic [XLEN-1:0] exc_pc_i,
  input logic            rfe_i,
  input logic [XLEN-1:0] sr_o,
  input logic [XLEN-1:0] cause_o,
  input logic [XLEN-1:0] epc_o,
  input logic            redirect_valid_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            swi_req_o
);
  assert_entry_push_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> (sr_o[5:0] == {$past(sr_o[3:0]), 2'b00}) &&
                         (sr_o[XLEN-1:6] == $past(sr_o[XLEN-1:6])));

  assert_return_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redirect_valid_o && $past(rfe_i)) |->
      (sr_o[3:0] == $past(sr_o[5:2])) && (sr_o[XLEN-1:4] == $past(sr_o[XLEN-1:4])));

  assert_sw_pending_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> cause_o[9:8] == $past(cause_o[9:8]));

  assert_epc_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> epc_o == ($past(exc_in_slot_i) ? $past(exc_pc_i) - XLEN'(4)
                                                        : $past(exc_pc_i)));

  assert_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> (redirect_pc_o == GEN_VEC) || (redirect_pc_o == DBG_VEC));

  assert_swi_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_o[0] |-> !swi_req_o);

  assert_one_per_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> !redirect_valid_o);

  assert_pc_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_valid_o |-> $stable(redirect_pc_o));
endmodule

bind trap_sequencer trap_sequencer_chk #(
  .XLEN(XLEN), .GEN_VEC(GEN_VEC), .DBG_VEC(DBG_VEC)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .exc_in_slot_i    (exc_in_slot_i),
  .exc_pc_i         (exc_pc_i),
  .rfe_i            (rfe_i),
  .sr_o             (sr_o),
  .cause_o          (cause_o),
  .epc_o            (epc_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o),
  .swi_req_o        (swi_req_o)
);

// File: tb/trap_sequencer_bench.sv
`timescale 1ns/1ps
module trap_sequencer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exc_req_i, exc_dbg_i, exc_in_slot_i, exc_br_taken_i, exc_from_insn_i;
  logic [4:0]  exc_code_i;
  logic [31:0] exc_pc_i;
  logic [1:0]  exc_cop_i;
  logic        creg_rd_i;
  logic [4:0]  creg_idx_i;
  logic        rfe_i, sr_we_i, cause_we_i;
  logic [31:0] wdata_i;
  logic [31:0] sr_o, cause_o, epc_o, redirect_pc_o;
  logic        redirect_valid_o, swi_req_o;

  always #2.5 clk_i = ~clk_i;

  trap_sequencer u_trap_sequencer (.*);

  typedef struct packed {
    logic [31:0] sr, cause, epc, rpc;
    logic        rv, swi;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, failures = 0;
  bit    done = 0;

  logic [31:0] m_sr = 0, m_cause = 0, m_epc = 0, m_rpc = 0;
  logic        m_rv = 0;

  task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, expv);
    end
  endtask

  task automatic idle();
    exc_req_i = 0; exc_dbg_i = 0; exc_code_i = 0; exc_pc_i = 0;
    exc_in_slot_i = 0; exc_br_taken_i = 0; exc_from_insn_i = 0; exc_cop_i = 0;
    creg_rd_i = 0; creg_idx_i = 0; rfe_i = 0; sr_we_i = 0; cause_we_i = 0; wdata_i = 0;
  endtask

  // model from requirements; inputs are already driven
  task automatic step(string tag);
    exp_t e;
    logic rd_fault, take, cop_en;
    logic [4:0] code;
    rd_fault = creg_rd_i && (creg_idx_i inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd10});
    take = (exc_req_i || rd_fault) && !m_rv;
    if (take) begin
      code   = exc_req_i ? (exc_dbg_i ? 5'd9 : exc_code_i) : 5'd10;
      cop_en = exc_req_i ? (exc_from_insn_i && !exc_dbg_i) : 1'b1;
      m_sr   = {m_sr[31:6], m_sr[3:0], 2'b00};
      m_cause = {exc_in_slot_i, exc_in_slot_i & exc_br_taken_i,
                 cop_en ? exc_cop_i : 2'b00, 18'd0, m_cause[9:8], 1'b0, code, 2'b00};
      m_epc  = exc_in_slot_i ? exc_pc_i - 32'd4 : exc_pc_i;
      m_rpc  = (exc_req_i && exc_dbg_i) ? 32'h8000_0040 : 32'h8000_0080;
      m_rv   = 1;
    end else begin
      m_rv = 0;
      if (rfe_i) m_sr[3:0] = m_sr[5:2];
      else begin
        if (sr_we_i) m_sr = wdata_i;
        if (cause_we_i) m_cause[9:8] = wdata_i[9:8];
      end
    end
    e.sr = m_sr; e.cause = m_cause; e.epc = m_epc; e.rpc = m_rpc; e.rv = m_rv;
    e.swi = m_sr[0] && |(m_cause[9:8] & m_sr[9:8]);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    idle();
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "sr",    sr_o,    e.sr);
      chk(t, "cause", cause_o, e.cause);
      chk(t, "epc",   epc_o,   e.epc);
      chk(t, "rpc",   redirect_pc_o, e.rpc);
      chk(t, "rv",    {31'd0, redirect_valid_o}, {31'd0, e.rv});
      chk(t, "swi",   {31'd0, swi_req_o},        {31'd0, e.swi});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "sr", sr_o, 0);
    chk("R1", "cause", cause_o, 0);
    chk("R1", "epc", epc_o, 0);
    chk("R1", "rpc", redirect_pc_o, 0);
    chk("R1", "rv_swi", {30'd0, redirect_valid_o, swi_req_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R9 R11 software interrupt via writes
    sr_we_i = 1; wdata_i = 32'h0000_0301; step("R11_sr_write");
    cause_we_i = 1; wdata_i = 32'hFFFF_FFFF; step("R9_swi_on");
    sr_we_i = 1; wdata_i = 32'h0000_0300; step("R9_ie_off");
    cause_we_i = 1; wdata_i = 32'h0; step("R9_clear");

    // nested traps: stack bits 5:0 = 101101
    sr_we_i = 1; wdata_i = 32'h1234_562D; step("R11_stack_seed");
    exc_req_i = 1; exc_code_i = 5'd8; exc_pc_i = 32'h0000_0100; step("R2_R4_trap1");
    step("R12_hold1");
    exc_req_i = 1; exc_code_i = 5'd11; exc_pc_i = 32'h0000_0200; exc_in_slot_i = 1;
    exc_br_taken_i = 1; exc_from_insn_i = 1; exc_cop_i = 2'b10; step("R5_R6_trap2");
    step("R12_hold2");
    exc_req_i = 1; exc_dbg_i = 1; exc_code_i = 5'd4; exc_pc_i = 32'h0000_0300;
    exc_in_slot_i = 1; exc_from_insn_i = 1; exc_cop_i = 2'b11; step("R7_dbg_trap3");
    step("R12_hold3");
    rfe_i = 1; step("R3_ret1");
    rfe_i = 1; step("R3_ret2");
    rfe_i = 1; step("R3_ret3");

    // R10 back-to-back
    exc_req_i = 1; exc_code_i = 5'd12; exc_pc_i = 32'h0000_0400; step("R10_first");
    exc_req_i = 1; exc_code_i = 5'd13; exc_pc_i = 32'h0000_0500; exc_in_slot_i = 1;
    step("R10_ignored");
    step("R10_idle");

    // R8 reserved register reads
    creg_rd_i = 1; creg_idx_i = 5'd4; exc_pc_i = 32'h0000_0600; exc_cop_i = 2'b00;
    step("R8_idx4");
    step("R8_gap");
    creg_rd_i = 1; creg_idx_i = 5'd10; exc_pc_i = 32'h0000_0704; exc_in_slot_i = 1;
    exc_cop_i = 2'b01; step("R8_idx10");
    step("R8_gap2");
    creg_rd_i = 1; creg_idx_i = 5'd3; exc_pc_i = 32'h0000_0800; step("R8_idx3_none");
    creg_rd_i = 1; creg_idx_i = 5'd12; step("R8_idx12_none");

    // R11 collisions
    sr_we_i = 1; wdata_i = 32'h0000_03FF; step("R11_seed2");
    exc_req_i = 1; exc_code_i = 5'd1; exc_pc_i = 32'h0000_0900;
    sr_we_i = 1; wdata_i = 32'hDEAD_BEEF; step("R11_trap_over_write");
    step("R11_gap");
    rfe_i = 1; cause_we_i = 1; wdata_i = 32'h0000_0300; step("R11_rfe_over_write");
    cause_we_i = 1; wdata_i = 32'hFFFF_FCFF; step("R11_cause_only_sw");
    cause_we_i = 1; wdata_i = 32'h0000_0100; sr_we_i = 1; step("R11_both_writes");
    // R6 from_insn cleared gives zero cop bits
    exc_req_i = 1; exc_code_i = 5'd7; exc_cop_i = 2'b11; exc_pc_i = 32'h0000_0A00;
    step("R6_no_cop");
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule